// File: doc/BRIEF.md
# DMA Channel Reset and Restart Controller

This block holds the control state of a single DMA channel: its status flags, its transfer count, its current source, destination and shadow addresses, and the request it presents to the bus. Software stops the channel by writing a one to a reset bit. If a bus read or write for this channel is already in progress, that access runs to completion and is counted before any state is cleared. The reset bit reads back as one until the clear has happened, so software can poll it.

When the reset completes, the channel goes idle. Its source and destination addresses are loaded with their wrap boundaries, the shadow address becomes zero, and every status flag and the transfer count are cleared. The channel runs again only after a software request, or after a hardware request while the hardware-request enable is set. At the start of a transaction the reload value is copied into the transfer count, but only if the shadow address is nonzero. Each completed bus access lowers the count by one and moves both addresses forward by one. The access that ends the count finishes the transaction and raises the channel interrupt flag.

Top module: `dma_chan_ctl`

## Requirements
- R1: One cycle after a `kill_wr` pulse, `kill_busy` reads 1. It stays 1 while the reset is pending and returns to 0 by itself when the reset completes.
- R2: A pending reset completes at the first clock edge where `bus_busy` is 0. If an access is in flight, the reset waits for it, and that access's `bus_done` still counts as a transfer: both addresses advance by one while `kill_busy` is still 1.
- R3: Completing a reset clears `hw_en`, `req_pend`, `req_lost`, `irq_ch`, `irq_pat`, `src_wrapped`, `dst_wrapped`, `last_xfer` and `tcount`.
- R4: Completing a reset loads `src_addr` with the stored source wrap boundary and `dst_addr` with the stored destination wrap boundary, and sets `shadow_addr` to 0.
- R5: After a reset completes, the channel stays idle with `bus_req` at 0 and its count unchanged until a request is accepted.
- R6: A `hw_req` line is acted on only while `hw_en` is 1. `hwen_wr` writes `hwen_val` into `hw_en`.
- R7: A request accepted while the channel is idle starts a transaction and raises `bus_req` in the next cycle. At that start, `tcount` takes `cfg_reload` if `shadow_addr` is nonzero and otherwise keeps its value.
- R8: A request that arrives in the same cycle as `kill_wr`, or while a reset is pending, is discarded: it neither starts a transaction nor sets `req_pend`.
- R9: `bus_req` is 0 in every cycle in which `kill_busy` is 1.
- R10: Each `bus_done` while the channel runs lowers `tcount` by one (never below 0) and increments `src_addr` and `dst_addr`. A `bus_done` that arrives with `tcount` at 1 or 0 ends the transaction: `tcount` becomes 0, `irq_ch` and `last_xfer` become 1, and `bus_req` drops unless a restart follows.
- R11: A request accepted during a running transaction sets `req_pend`. A further request while `req_pend` is 1 sets `req_lost`. When the transaction ends with `req_pend` at 1, a new transaction starts at once under the reload rule of R7 and `req_pend` clears.
- R12: Pulses on `evt_pat`, `evt_src_wrap` and `evt_dst_wrap` set the sticky flags `irq_pat`, `src_wrapped` and `dst_wrapped`.
- R13: While `rst` is 1, every output becomes 0, which is the reset-complete state with both wrap boundaries at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| kill_wr | input | 1 | Software writes 1 to the channel reset bit |
| hwen_wr | input | 1 | Write strobe for the hardware-request enable |
| hwen_val | input | 1 | Value written to the hardware-request enable |
| sw_req | input | 1 | Software transaction request strobe |
| hw_req | input | HWL | Hardware request lines, OR-combined |
| cfg_wr | input | 1 | Loads reload value, addresses and wrap boundaries |
| cfg_reload | input | CW | Transfer reload value |
| cfg_src | input | AW | Source address |
| cfg_dst | input | AW | Destination address |
| cfg_shadow | input | AW | Shadow address |
| cfg_src_wrap | input | AW | Source wrap boundary |
| cfg_dst_wrap | input | AW | Destination wrap boundary |
| evt_pat | input | 1 | Pattern-match event from the data path |
| evt_src_wrap | input | 1 | Source wrap event from the data path |
| evt_dst_wrap | input | 1 | Destination wrap event from the data path |
| bus_busy | input | 1 | An access for this channel is in flight |
| bus_done | input | 1 | The in-flight access completes this cycle |
| kill_busy | output | 1 | Reset bit readback: 1 while the reset is pending |
| hw_en | output | 1 | Hardware-request enable status |
| req_pend | output | 1 | A further transaction request is waiting |
| req_lost | output | 1 | A request was lost because one was already waiting |
| irq_ch | output | 1 | Channel interrupt flag (transaction ended) |
| irq_pat | output | 1 | Pattern-match interrupt flag |
| src_wrapped | output | 1 | Source wrap flag |
| dst_wrapped | output | 1 | Destination wrap flag |
| last_xfer | output | 1 | Marks that the last transfer of a transaction has completed |
| tcount | output | CW | Remaining transfer count |
| src_addr | output | AW | Current source address |
| dst_addr | output | AW | Current destination address |
| shadow_addr | output | AW | Shadow address |
| bus_req | output | 1 | The channel requests a bus access |

## Verification
The assertions check on every cycle that a pending reset cannot complete while an access is in flight. They also check that the cycle after a reset completes shows cleared flags, a zero count, zero shadow and addresses at the boundaries. Further checks are that the count only rises at a transaction start, that a lost request needs a pending one, and that no transaction starts while a reset is pending. The bench scenarios are needed to show the ordering across several cycles: an in-flight access that advances the addresses while the reset bit still reads one, and a queued request that restarts with a fresh count at the end of a transaction. They also show that the reload is skipped when the shadow address is zero, and that hardware lines stay idle once the enable has been cleared.

// File: rtl/dcr_pkg.sv
`timescale 1ns/1ps
package dcr_pkg;
  typedef enum logic {CH_IDLE = 1'b0, CH_RUN = 1'b1} ch_state_e;

  typedef struct packed {
    logic hw_en;
    logic req_pend;
    logic req_lost;
    logic irq_ch;
    logic irq_pat;
    logic wrap_src;
    logic wrap_dst;
    logic last_xfer;
  } ch_flags_t;
endpackage

// File: rtl/dcr_kill_seq.sv
`timescale 1ns/1ps
module dcr_kill_seq (
  input  logic clk,
  input  logic rst,
  input  logic kill_wr,
  input  logic bus_busy,
  output logic kill_pend,
  output logic kill_fire
);
  // Completion happens only in a cycle with no access in flight.
  assign kill_fire = kill_pend && !bus_busy;

  always_ff @(posedge clk) begin
    if (rst)            kill_pend <= 1'b0;
    else if (kill_wr)   kill_pend <= 1'b1;
    else if (kill_fire) kill_pend <= 1'b0;
  end

  assert_kill_visible_R1: assert property (@(posedge clk) disable iff (rst)
    kill_wr |=> kill_pend);
  assert_wait_inflight_R2: assert property (@(posedge clk) disable iff (rst)
    (kill_pend && bus_busy) |=> kill_pend);
  assert_fall_idle_bus_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(kill_pend) |-> $past(!bus_busy));
endmodule

// File: rtl/dcr_req_gate.sv
`timescale 1ns/1ps
module dcr_req_gate #(
  parameter int HWL = 2
) (
  input  logic           hw_en,
  input  logic [HWL-1:0] hw_req,
  input  logic           sw_req,
  input  logic           kill_wr,
  input  logic           kill_pend,
  output logic           req_now
);
  logic [HWL-1:0] hw_gated;

  genvar gi;
  generate
    for (gi = 0; gi < HWL; gi++) begin : g_line
      assign hw_gated[gi] = hw_req[gi] & hw_en;
    end
  endgenerate

  // A reset being written or pending discards every request.
  assign req_now = ((|hw_gated) || sw_req) && !kill_wr && !kill_pend;
endmodule

// File: rtl/dcr_addr_regs.sv
`timescale 1ns/1ps
module dcr_addr_regs #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [AW-1:0] cfg_shadow,
  input  logic [AW-1:0] cfg_src_wrap,
  input  logic [AW-1:0] cfg_dst_wrap,
  input  logic          beat,
  input  logic          kill_fire,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic [AW-1:0] shadow_addr,
  output logic          shadow_nz
);
  localparam logic [AW-1:0] STEP = AW'(1);

  logic [AW-1:0] swrap_q, dwrap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      swrap_q <= '0;
      dwrap_q <= '0;
    end else if (cfg_wr) begin
      swrap_q <= cfg_src_wrap;
      dwrap_q <= cfg_dst_wrap;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_addr    <= '0;
      dst_addr    <= '0;
      shadow_addr <= '0;
    end else if (kill_fire) begin
      src_addr    <= swrap_q;
      dst_addr    <= dwrap_q;
      shadow_addr <= '0;
    end else if (cfg_wr) begin
      src_addr    <= cfg_src;
      dst_addr    <= cfg_dst;
      shadow_addr <= cfg_shadow;
    end else if (beat) begin
      src_addr <= src_addr + STEP;
      dst_addr <= dst_addr + STEP;
    end
  end

  assign shadow_nz = |shadow_addr;

  assert_load_boundary_R4: assert property (@(posedge clk) disable iff (rst)
    kill_fire |=> (src_addr == $past(swrap_q) && dst_addr == $past(dwrap_q)
                   && shadow_addr == '0));
  assert_addr_step_R10: assert property (@(posedge clk) disable iff (rst)
    (beat && !kill_fire && !cfg_wr) |=> (src_addr == $past(src_addr) + STEP));
endmodule

// File: rtl/dcr_xfer_ctl.sv
`timescale 1ns/1ps
module dcr_xfer_ctl
  import dcr_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_now,
  input  logic          kill_fire,
  input  logic          bus_done,
  input  logic          shadow_nz,
  input  logic          cfg_wr,
  input  logic [CW-1:0] cfg_reload,
  input  logic          hwen_wr,
  input  logic          hwen_val,
  input  logic          evt_pat,
  input  logic          evt_src_wrap,
  input  logic          evt_dst_wrap,
  output ch_flags_t     flags,
  output logic [CW-1:0] tcount,
  output logic          run,
  output logic          beat
);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  ch_state_e     st_q, st_n;
  ch_flags_t     fl_n;
  logic [CW-1:0] cnt_n, reload_q;
  logic          start;
  logic          ends;

  assign run  = (st_q == CH_RUN);
  assign beat = run && bus_done;
  assign ends = beat && (tcount <= CNT_ONE);

  always_ff @(posedge clk) begin
    if (rst)         reload_q <= '0;
    else if (cfg_wr) reload_q <= cfg_reload;
  end

  always_comb begin
    st_n  = st_q;
    cnt_n = tcount;
    fl_n  = flags;
    start = 1'b0;
    if (hwen_wr)      fl_n.hw_en    = hwen_val;
    if (evt_pat)      fl_n.irq_pat  = 1'b1;
    if (evt_src_wrap) fl_n.wrap_src = 1'b1;
    if (evt_dst_wrap) fl_n.wrap_dst = 1'b1;
    if (run) begin
      if (beat) cnt_n = (tcount == '0) ? '0 : tcount - CNT_ONE;
      if (ends) begin
        fl_n.irq_ch    = 1'b1;
        fl_n.last_xfer = 1'b1;
        if (flags.req_pend) begin
          start         = 1'b1;
          fl_n.req_pend = req_now;
        end else if (req_now) begin
          start = 1'b1;
        end else begin
          st_n = CH_IDLE;
        end
      end else if (req_now) begin
        if (flags.req_pend) fl_n.req_lost = 1'b1;
        else                fl_n.req_pend = 1'b1;
      end
    end else if (req_now) begin
      start          = 1'b1;
      st_n           = CH_RUN;
      fl_n.last_xfer = 1'b0;
    end
    if (start && shadow_nz) cnt_n = reload_q;
  end

  always_ff @(posedge clk) begin
    if (rst || kill_fire) begin
      st_q   <= CH_IDLE;
      tcount <= '0;
      flags  <= '0;
    end else begin
      st_q   <= st_n;
      tcount <= cnt_n;
      flags  <= fl_n;
    end
  end

  assert_cnt_rise_start_R7: assert property (@(posedge clk) disable iff (rst)
    (tcount > $past(tcount)) |-> $past(start));
  assert_lost_needs_pend_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(flags.req_lost) |-> $past(flags.req_pend));
  assert_irq_on_done_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(flags.irq_ch) |-> $past(bus_done && run));
endmodule

// File: rtl/dma_chan_ctl.sv
`timescale 1ns/1ps
module dma_chan_ctl
  import dcr_pkg::*;
#(
  parameter int AW  = 16,
  parameter int CW  = 8,
  parameter int HWL = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           kill_wr,
  input  logic           hwen_wr,
  input  logic           hwen_val,
  input  logic           sw_req,
  input  logic [HWL-1:0] hw_req,
  input  logic           cfg_wr,
  input  logic [CW-1:0]  cfg_reload,
  input  logic [AW-1:0]  cfg_src,
  input  logic [AW-1:0]  cfg_dst,
  input  logic [AW-1:0]  cfg_shadow,
  input  logic [AW-1:0]  cfg_src_wrap,
  input  logic [AW-1:0]  cfg_dst_wrap,
  input  logic           evt_pat,
  input  logic           evt_src_wrap,
  input  logic           evt_dst_wrap,
  input  logic           bus_busy,
  input  logic           bus_done,
  output logic           kill_busy,
  output logic           hw_en,
  output logic           req_pend,
  output logic           req_lost,
  output logic           irq_ch,
  output logic           irq_pat,
  output logic           src_wrapped,
  output logic           dst_wrapped,
  output logic           last_xfer,
  output logic [CW-1:0]  tcount,
  output logic [AW-1:0]  src_addr,
  output logic [AW-1:0]  dst_addr,
  output logic [AW-1:0]  shadow_addr,
  output logic           bus_req
);
  ch_flags_t flags;
  logic kill_pend, kill_fire, req_now, run, beat, shadow_nz;

  dcr_kill_seq u_kill (
    .clk(clk), .rst(rst), .kill_wr(kill_wr), .bus_busy(bus_busy),
    .kill_pend(kill_pend), .kill_fire(kill_fire)
  );

  dcr_req_gate #(.HWL(HWL)) u_gate (
    .hw_en(flags.hw_en), .hw_req(hw_req), .sw_req(sw_req),
    .kill_wr(kill_wr), .kill_pend(kill_pend), .req_now(req_now)
  );

  dcr_xfer_ctl #(.CW(CW)) u_xfer (
    .clk(clk), .rst(rst), .req_now(req_now), .kill_fire(kill_fire),
    .bus_done(bus_done), .shadow_nz(shadow_nz), .cfg_wr(cfg_wr),
    .cfg_reload(cfg_reload), .hwen_wr(hwen_wr), .hwen_val(hwen_val),
    .evt_pat(evt_pat), .evt_src_wrap(evt_src_wrap), .evt_dst_wrap(evt_dst_wrap),
    .flags(flags), .tcount(tcount), .run(run), .beat(beat)
  );

  dcr_addr_regs #(.AW(AW)) u_addr (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_src(cfg_src),
    .cfg_dst(cfg_dst), .cfg_shadow(cfg_shadow), .cfg_src_wrap(cfg_src_wrap),
    .cfg_dst_wrap(cfg_dst_wrap), .beat(beat), .kill_fire(kill_fire),
    .src_addr(src_addr), .dst_addr(dst_addr), .shadow_addr(shadow_addr),
    .shadow_nz(shadow_nz)
  );

  assign kill_busy   = kill_pend;
  assign hw_en       = flags.hw_en;
  assign req_pend    = flags.req_pend;
  assign req_lost    = flags.req_lost;
  assign irq_ch      = flags.irq_ch;
  assign irq_pat     = flags.irq_pat;
  assign src_wrapped = flags.wrap_src;
  assign dst_wrapped = flags.wrap_dst;
  assign last_xfer   = flags.last_xfer;
  // No new access is requested once a reset is pending.
  assign bus_req     = run && !kill_pend;

  assert_clear_on_done_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(kill_pend) |-> (flags == '0 && tcount == '0 && shadow_addr == '0));
  assert_no_start_killing_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> $past(!kill_pend && !kill_wr));
endmodule

// File: tb/sim_dma_chan_ctl.sv
`timescale 1ns/1ps
module sim_dma_chan_ctl;
  localparam int AW = 16, CW = 8, HWL = 2;
  localparam int F_KILL = 0, F_HWEN = 1, F_PEND = 2, F_LOST = 3, F_IRQ = 4,
                 F_PAT = 5, F_SWR = 6, F_DWR = 7, F_LAST = 8, F_CNT = 9,
                 F_SRC = 10, F_DST = 11, F_SHD = 12, F_BREQ = 13;

  logic clk = 0, rst = 1;
  logic kill_wr = 0, hwen_wr = 0, hwen_val = 0, sw_req = 0, cfg_wr = 0;
  logic [HWL-1:0] hw_req = '0;
  logic [CW-1:0] cfg_reload = '0;
  logic [AW-1:0] cfg_src = '0, cfg_dst = '0, cfg_shadow = '0, cfg_src_wrap = '0, cfg_dst_wrap = '0;
  logic evt_pat = 0, evt_src_wrap = 0, evt_dst_wrap = 0;
  logic bus_busy = 0, bus_done = 0;
  logic kill_busy, hw_en, req_pend, req_lost, irq_ch, irq_pat, src_wrapped, dst_wrapped, last_xfer, bus_req;
  logic [CW-1:0] tcount;
  logic [AW-1:0] src_addr, dst_addr, shadow_addr;

  int checks = 0, fails = 0;
  bit ended = 0;
  bit bus_en = 0;
  int lat = 1, bcnt = 0;
  int q_sel[$];
  int q_exp[$];
  string q_req[$];

  always #10 clk = ~clk;

  dma_chan_ctl #(.AW(AW), .CW(CW), .HWL(HWL)) u0 (.*);

  // Simple bus target: grants when idle, holds busy for lat cycles, pulses done.
  always @(negedge clk) begin
    if (bus_done) begin bus_done <= 0; bus_busy <= 0; end
    else if (bus_busy) begin
      if (bcnt == 0) bus_done <= 1; else bcnt <= bcnt - 1;
    end else if (bus_req && bus_en) begin bus_busy <= 1; bcnt <= lat; end
  end

  function automatic int obs(int sel);
    case (sel)
      F_KILL: return int'(kill_busy);
      F_HWEN: return int'(hw_en);
      F_PEND: return int'(req_pend);
      F_LOST: return int'(req_lost);
      F_IRQ:  return int'(irq_ch);
      F_PAT:  return int'(irq_pat);
      F_SWR:  return int'(src_wrapped);
      F_DWR:  return int'(dst_wrapped);
      F_LAST: return int'(last_xfer);
      F_CNT:  return int'(tcount);
      F_SRC:  return int'(src_addr);
      F_DST:  return int'(dst_addr);
      F_SHD:  return int'(shadow_addr);
      default: return int'(bus_req);
    endcase
  endfunction

  // Monitor: compares queued expectations away from the active edge.
  always @(negedge clk) begin
    while (q_sel.size() > 0) begin
      int s, e, a;
      string r;
      s = q_sel.pop_front(); e = q_exp.pop_front(); r = q_req.pop_front();
      a = obs(s);
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s field %0d: actual %0h expected %0h", r, s, a, e);
      end
    end
  end

  task automatic expect_f(input string r, input int sel, input int e);
    q_sel.push_back(sel); q_exp.push_back(e); q_req.push_back(r);
  endtask

  task automatic step();
    @(posedge clk); #5;
  endtask

  task automatic pulse_sw();  sw_req = 1;  step(); sw_req = 0;  endtask
  task automatic pulse_kill(); kill_wr = 1; step(); kill_wr = 0; endtask

  task automatic config_all(input int rl, input int s, input int d, input int sh, input int sw, input int dw);
    cfg_reload = CW'(rl); cfg_src = AW'(s); cfg_dst = AW'(d); cfg_shadow = AW'(sh);
    cfg_src_wrap = AW'(sw); cfg_dst_wrap = AW'(dw);
    cfg_wr = 1; step(); cfg_wr = 0;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 200 && irq_ch !== 1'b1; i++) step();
  endtask

  initial begin
    int prev, beats;
    @(posedge clk); #5; step(); step();
    // R13: everything zero under system reset
    expect_f("R13", F_KILL, 0); expect_f("R13", F_CNT, 0); expect_f("R13", F_SRC, 0);
    expect_f("R13", F_HWEN, 0); expect_f("R13", F_BREQ, 0); expect_f("R13", F_IRQ, 0);
    rst = 0; step();

    config_all(3, 'h100, 'h200, 'h40, 'h80, 'h90);
    expect_f("R4", F_SRC, 'h100); expect_f("R4", F_SHD, 'h40);
    // R7: start from idle with nonzero shadow reloads the count
    pulse_sw();
    expect_f("R7", F_BREQ, 1); expect_f("R7", F_CNT, 3);
    step();
    // R10: run three transfers to the end
    bus_en = 1; lat = 1; wait_irq(); bus_en = 0;
    expect_f("R10", F_CNT, 0); expect_f("R10", F_LAST, 1); expect_f("R10", F_IRQ, 1);
    expect_f("R10", F_SRC, 'h103); expect_f("R10", F_DST, 'h203); expect_f("R10", F_BREQ, 0);
    step();

    // R6: hardware line ignored while disabled, accepted once enabled
    hw_req = 2'b10; step(); hw_req = '0;
    expect_f("R6", F_BREQ, 0); expect_f("R6", F_CNT, 0);
    step();
    hwen_val = 1; hwen_wr = 1; step(); hwen_wr = 0;
    expect_f("R6", F_HWEN, 1);
    hw_req = 2'b01; step(); hw_req = '0;
    expect_f("R6", F_BREQ, 1); expect_f("R6", F_CNT, 3);
    step();

    // R11: queue one request, lose the next, restart at end
    pulse_sw(); expect_f("R11", F_PEND, 1); expect_f("R11", F_LOST, 0);
    step();
    pulse_sw(); expect_f("R11", F_LOST, 1);
    bus_en = 1; lat = 1; beats = 0;
    for (int i = 0; i < 200 && beats < 3; i++) begin step(); if (bus_done) beats++; end
    bus_en = 0;
    expect_f("R11", F_CNT, 3); expect_f("R11", F_PEND, 0); expect_f("R11", F_BREQ, 1);
    step();

    // R12: sticky data path event flags
    evt_pat = 1; evt_src_wrap = 1; evt_dst_wrap = 1; step();
    evt_pat = 0; evt_src_wrap = 0; evt_dst_wrap = 0;
    expect_f("R12", F_PAT, 1); expect_f("R12", F_SWR, 1); expect_f("R12", F_DWR, 1);
    step();

    // R1/R2/R9: reset while an access is in flight
    bus_en = 1; lat = 4;
    for (int i = 0; i < 50 && bus_busy !== 1'b1; i++) step();
    bus_en = 0;
    pulse_kill();
    expect_f("R1", F_KILL, 1); expect_f("R9", F_BREQ, 0);
    prev = int'(src_addr);
    for (int i = 0; i < 50; i++) begin
      prev = int'(src_addr); step();
      if (bus_done) break;
    end
    expect_f("R2", F_SRC, (prev + 1) & 'hffff); expect_f("R2", F_KILL, 1);
    step();
    expect_f("R1", F_KILL, 0);
    expect_f("R3", F_HWEN, 0); expect_f("R3", F_PEND, 0); expect_f("R3", F_LOST, 0);
    expect_f("R3", F_IRQ, 0); expect_f("R3", F_PAT, 0); expect_f("R3", F_SWR, 0);
    expect_f("R3", F_DWR, 0); expect_f("R3", F_LAST, 0); expect_f("R3", F_CNT, 0);
    expect_f("R4", F_SRC, 'h80); expect_f("R4", F_DST, 'h90); expect_f("R4", F_SHD, 0);
    step(); step(); step();
    expect_f("R5", F_BREQ, 0); expect_f("R5", F_CNT, 0); expect_f("R5", F_KILL, 0);
    hw_req = 2'b11; step(); hw_req = '0;
    expect_f("R6", F_BREQ, 0);
    step();

    // R8: request with the reset write and while it is pending
    kill_wr = 1; sw_req = 1; step(); kill_wr = 0;
    expect_f("R8", F_KILL, 1); expect_f("R8", F_BREQ, 0);
    step(); sw_req = 0;
    expect_f("R8", F_KILL, 0); expect_f("R8", F_BREQ, 0); expect_f("R8", F_PEND, 0);
    step();

    // R7: shadow zero keeps the count; single transfer ends
    pulse_sw();
    expect_f("R7", F_BREQ, 1); expect_f("R7", F_CNT, 0);
    step();
    bus_en = 1; lat = 0; wait_irq(); bus_en = 0;
    expect_f("R10", F_LAST, 1); expect_f("R10", F_CNT, 0); expect_f("R10", F_BREQ, 0);
    expect_f("R10", F_SRC, 'h81);
    step();
    config_all(2, 'h10, 'h20, 'h44, 'h80, 'h90);
    hwen_val = 1; hwen_wr = 1; step(); hwen_wr = 0;
    hw_req = 2'b01; step(); hw_req = '0;
    expect_f("R7", F_CNT, 2); expect_f("R6", F_BREQ, 1);
    step(); step();

    ended = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!ended) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule